// File: doc/BRIEF.md
# Dual-Width Read-Only Memory Read Port

This block is a synthesizable, cycle-based model of the read side of a one-time-programmable 4-Mbit memory. The memory can be read as 16-bit words or as 8-bit bytes, and a width-select input picks between them. In byte mode the top data line stops carrying data and becomes the lowest address bit, which picks one byte of the stored word. The block decodes chip enable and output enable into standby, output-disable and read modes, and it steers byte lanes with per-lane output enables. It also returns a two-byte identifier when a flag stands in for the high-voltage condition on an address pin.

Access latency is counted in clock cycles. Moving to a new group of four words, or selecting the chip, or changing the read mode costs the full latency. Moving only among the words (or bytes) of the current group costs half of it. A data-valid strobe marks the cycles in which the output may be sampled. The storage is a small parameterised array that comes out of reset fully erased. A program port can only clear bits, in the way a one-time-programmable cell behaves.

Top module: `dual_width_rom_reader`

## Requirements
- R1: While `cs_n` is 1, `dq_oe` is 16'h0000 and `data_valid` is 0, whatever the other inputs are.
- R2: While `cs_n` is 0 and `oe_n` is 1, `dq_oe` is 16'h0000 and `data_valid` is 0.
- R3: In a read with `cs_n`=0, `oe_n`=0, `id_sel`=0 and `byte_mode`=0, `dq_oe` is 16'hFFFF and `dq_out` is the stored word at the address.
- R4: In a byte read (`byte_mode`=1), `dq_oe` is 16'h00FF and `dq_out[15:8]` is 0. With `lsb_in`=0, `dq_out[7:0]` is bits 7:0 of the stored word. With `lsb_in`=1, it is bits 15:8.
- R5: After reset every stored word reads 16'hFFFF.
- R6: At a rising edge with `pgm_en`=1, the word at `addr` becomes its old value AND `pgm_data`. Bits are only ever cleared.
- R7: With `cs_n`=0, `oe_n`=0 and `id_sel`=1, `dq_out[7:0]` is 8'h07 when `addr[0]` is 0 and 8'hA1 when it is 1. All other address bits are ignored, and `dq_out[15:8]` is 0.
- R8: After the chip is selected, or after a change in `addr[17:2]`, `byte_mode` or `id_sel`, `data_valid` is 0 for the next FULL_LAT-1 rising edges and 1 after the FULL_LAT-th edge (FULL_LAT=6 by default).
- R9: A change only in the burst-select bits (`addr[1:0]`, plus `lsb_in` in byte mode) makes `data_valid` rise after FULL_LAT/2 edges (3 by default).
- R10: In word mode `lsb_in` is ignored: toggling it changes neither `dq_out` nor `data_valid`.
- R11: Once `data_valid` is 1, it stays 1 for as long as the inputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 selects 8-bit reads, 0 selects 16-bit reads |
| id_sel | input | 1 | Identifier condition flag |
| addr | input | 18 | Word address; bits 1:0 select within a burst group |
| lsb_in | input | 1 | Byte-select bit taken from the top data line in byte mode |
| pgm_en | input | 1 | Program strobe (clears bits at addr) |
| pgm_data | input | 16 | Program data; 0 bits are cleared |
| dq_out | output | 16 | Data lines |
| dq_oe | output | 16 | Per-lane output enables |
| data_valid | output | 1 | Access latency has expired and outputs are driven |

## Verification
The hardest case to reach is a burst-length reload inside byte mode. To get there, the bench first has to complete a full-latency access in byte mode, which requires a mode change. Only after that full access can it move `lsb_in` alone, and then `addr[1:0]` alone, within the same word group. The stimulus programs distinct patterns into two neighbouring words of one group, so each byte the port selects is unique. It then walks the select bits one at a time and counts rising edges up to the first valid cycle. A companion step toggles `lsb_in` in word mode and confirms that no reload follows.

// File: rtl/rom_rd_pkg.sv
// Package: shared constants and types for the dual-width read port.
// Assumes: identifier codes are fixed; lane modes are decoded once in lane steering.
package rom_rd_pkg;
    localparam logic [7:0] ID_MFR_CODE = 8'h07;
    localparam logic [7:0] ID_DEV_CODE = 8'hA1;

    typedef enum logic [1:0] {
        LM_OFF   = 2'd0,
        LM_WORD  = 2'd1,
        LM_BYTE  = 2'd2,
        LM_IDENT = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/rom_cell_array.sv
// Module: rom_cell_array
// Holds WORDS x DATA_W cells. Reset fills every cell with ones (erased).
// Programming ANDs data into a cell, so bits can only go from 1 to 0.
// Assumes: the address is already truncated to the array index width.
module rom_cell_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pgm_en,
    input  logic [DATA_W-1:0] pgm_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [WORDS];

    // Erase on reset; clear-only programming otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (pgm_en) begin
            cells[idx] <= cells[idx] & pgm_data;
        end
    end

    // Asynchronous read of the addressed cell.
    assign rd_data = cells[idx];

    // R6: programming never sets a bit in the addressed cell.
    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> (!$stable(idx) || ((rd_data & ~$past(rd_data)) == '0)));
endmodule

// File: rtl/rom_access_timer.sv
// Module: rom_access_timer
// Counts access latency in cycles. Selecting the chip, or changing the group
// or the mode, reloads FULL_LAT-1. A change only in the burst-select bits
// reloads half of it. The valid strobe is high when the count is spent and
// nothing changed this cycle.
// Assumes: FULL_LAT >= 2.
module rom_access_timer #(
    parameter int FULL_LAT = 6,
    parameter int PAGE_W   = 16,
    parameter int SEL_W    = 3,
    parameter int MODE_W   = 2,
    localparam int BURST_LAT = FULL_LAT / 2,
    localparam int CNT_W     = $clog2(FULL_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              drive_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [SEL_W-1:0]  sel,
    input  logic [MODE_W-1:0] mode,
    output logic              data_valid
);
    localparam logic [CNT_W-1:0] FULL_RELOAD  = CNT_W'(FULL_LAT - 1);
    localparam logic [CNT_W-1:0] BURST_RELOAD = CNT_W'(BURST_LAT - 1);

    logic              prev_active;
    logic [PAGE_W-1:0] prev_page;
    logic [SEL_W-1:0]  prev_sel;
    logic [MODE_W-1:0] prev_mode;
    logic [CNT_W-1:0]  cnt;
    logic              full_chg, burst_chg;

    // Classify this cycle's change against the previous cycle's inputs.
    always_comb begin
        full_chg  = active && (!prev_active || (page != prev_page) || (mode != prev_mode));
        burst_chg = active && !full_chg && (sel != prev_sel);
    end

    // Track previous inputs and run the latency count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_active <= 1'b0;
            prev_page   <= '0;
            prev_sel    <= '0;
            prev_mode   <= '0;
            cnt         <= '0;
        end else begin
            prev_active <= active;
            prev_page   <= page;
            prev_sel    <= sel;
            prev_mode   <= mode;
            if (full_chg)        cnt <= FULL_RELOAD;
            else if (burst_chg)  cnt <= BURST_RELOAD;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end
    end

    // Valid once the count is spent and the inputs have settled.
    assign data_valid = active && drive_en && !full_chg && !burst_chg && (cnt == '0);

    // R8: a full reload is never followed at once by a valid cycle.
    p_no_early_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_chg |=> !data_valid);

    // R9: a burst reload starts the shorter count.
    p_burst_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_chg |=> (!full_chg && cnt <= BURST_RELOAD));

    // R11: valid holds while the inputs stay put.
    p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> (data_valid || !active || !drive_en ||
                        (page != $past(page)) || (sel != $past(sel)) ||
                        (mode != $past(mode))));
endmodule

// File: rtl/rom_lane_steer.sv
// Module: rom_lane_steer
// Decodes chip and output enables into a lane mode. Places the stored word,
// one of its bytes, or an identifier code on the data lines, and sets the
// per-lane enables.
// Assumes: rd_word is the word at the current address.
module rom_lane_steer
    import rom_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic              id_sel,
    input  logic              a0,
    input  logic              lsb,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              drive_en
);
    lane_mode_e      lmode;
    logic [HALF_W-1:0] low_byte;

    // Mode decode: standby or output disable wins over everything.
    always_comb begin
        if (cs_n || oe_n)    lmode = LM_OFF;
        else if (id_sel)     lmode = LM_IDENT;
        else if (byte_mode)  lmode = LM_BYTE;
        else                 lmode = LM_WORD;
    end

    // Pick the byte for the low lane in byte mode.
    assign low_byte = lsb ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0];

    // Drive data lines and lane enables for the decoded mode.
    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        unique case (lmode)
            LM_WORD: begin
                dq_out = rd_word;
                dq_oe  = '1;
            end
            LM_BYTE: begin
                dq_out = {{HALF_W{1'b0}}, low_byte};
                dq_oe  = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            end
            LM_IDENT: begin
                dq_out = {{HALF_W{1'b0}}, (a0 ? ID_DEV_CODE : ID_MFR_CODE)};
                dq_oe  = byte_mode ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
            end
            default: ;
        endcase
    end

    assign drive_en = (lmode != LM_OFF);
endmodule

// File: rtl/dual_width_rom_reader.sv
// Module: dual_width_rom_reader (top)
// Read port of a dual-width one-time-programmable memory. Ties together the
// cell array, the lane steering and the latency timer.
// Assumes: lsb_in carries the byte-select bit; it counts only in byte mode.
module dual_width_rom_reader
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int WORDS    = 64,
    parameter int FULL_LAT = 6,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int PAGE_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              byte_mode,
    input  logic              id_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lsb_in,
    input  logic              pgm_en,
    input  logic [DATA_W-1:0] pgm_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              data_valid
);
    logic [DATA_W-1:0] rd_word;
    logic              drive_en;
    logic [2:0]        burst_sel;

    // Burst select: two word bits, plus the byte bit in byte mode only.
    assign burst_sel = {addr[1:0], byte_mode & lsb_in};

    rom_cell_array #(.WORDS(WORDS), .DATA_W(DATA_W)) i_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (addr[IDX_W-1:0]),
        .pgm_en   (pgm_en),
        .pgm_data (pgm_data),
        .rd_data  (rd_word)
    );

    rom_lane_steer #(.DATA_W(DATA_W)) i_steer (
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .byte_mode (byte_mode),
        .id_sel    (id_sel),
        .a0        (addr[0]),
        .lsb       (lsb_in),
        .rd_word   (rd_word),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .drive_en  (drive_en)
    );

    rom_access_timer #(
        .FULL_LAT (FULL_LAT),
        .PAGE_W   (PAGE_W),
        .SEL_W    (3),
        .MODE_W   (2)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (!cs_n),
        .drive_en   (drive_en),
        .page       (addr[ADDR_W-1:2]),
        .sel        (burst_sel),
        .mode       ({byte_mode, id_sel}),
        .data_valid (data_valid)
    );

    // R1: standby floats every lane and never flags valid data.
    p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (dq_oe == '0 && !data_valid));

    // R2: output disable floats every lane.
    p_disable_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && oe_n) |-> (dq_oe == '0 && !data_valid));

    // R4: in byte mode the upper lanes are neither enabled nor carrying data.
    p_byte_upper_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && !cs_n && !oe_n) |->
            (dq_oe[DATA_W-1:DATA_W/2] == '0 && dq_out[DATA_W-1:DATA_W/2] == '0));

    // R7: identifier code follows only address bit 0.
    p_ident_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && id_sel) |->
            (dq_out[7:0] == (addr[0] ? ID_DEV_CODE : ID_MFR_CODE)));
endmodule

// File: tb/test_dual_width_rom_reader.sv
`timescale 1ns/1ps
module test_dual_width_rom_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0, id_sel = 1'b0;
    logic [17:0] addr = '0;
    logic        lsb_in = 1'b0, pgm_en = 1'b0;
    logic [15:0] pgm_data = '0;
    logic [15:0] dq_out, dq_oe;
    logic        data_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dual_width_rom_reader i_dual_width_rom_reader (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n),
        .byte_mode(byte_mode), .id_sel(id_sel), .addr(addr), .lsb_in(lsb_in),
        .pgm_en(pgm_en), .pgm_data(pgm_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .data_valid(data_valid)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic c, input logic o, input logic bm, input logic id,
                         input logic [17:0] a, input logic l);
        @(negedge clk);
        cs_n = c; oe_n = o; byte_mode = bm; id_sel = id; addr = a; lsb_in = l;
        #1;
    endtask

    task automatic program_word(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; pgm_data = d; pgm_en = 1'b1;
        @(negedge clk);
        pgm_en = 1'b0;
    endtask

    // R1, R5: reset state and erased contents.
    task automatic t_reset_erased();
        chk("R1 standby lanes", dq_oe, 16'h0000);
        chk("R1 standby valid", {15'd0, data_valid}, 16'd0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'd9, 1'b0);
        edges(6);
        chk("R5 erased word", dq_out, 16'hFFFF);
        chk("R3 word lanes", dq_oe, 16'hFFFF);
    endtask

    // R6: programming only clears bits.
    task automatic t_program();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 18'd0, 1'b0);
        program_word(18'd3, 16'hA55A);
        program_word(18'd3, 16'h0FF0);
        program_word(18'd4, 16'h1234);
        program_word(18'd4, 16'hFFFF);
        program_word(18'd5, 16'hBEEF);
    endtask

    // R3, R8, R6: full-latency word reads.
    task automatic t_word_full();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'd3, 1'b0);
        edges(5);
        chk("R8 not valid before full latency", {15'd0, data_valid}, 16'd0);
        edges(1);
        chk("R8 valid at full latency", {15'd0, data_valid}, 16'd1);
        chk("R6 and-programmed word", dq_out, 16'h0550);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'd4, 1'b0);
        edges(5);
        chk("R8 group change reloads full", {15'd0, data_valid}, 16'd0);
        edges(1);
        chk("R8 valid after group change", {15'd0, data_valid}, 16'd1);
        chk("R6 reprogram with ones keeps word", dq_out, 16'h1234);
    endtask

    // R9, R10: burst step in word mode; lsb_in ignored.
    task automatic t_word_burst();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'd5, 1'b0);
        edges(2);
        chk("R9 burst not yet valid", {15'd0, data_valid}, 16'd0);
        edges(1);
        chk("R9 burst valid at half latency", {15'd0, data_valid}, 16'd1);
        chk("R3 burst word data", dq_out, 16'hBEEF);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 18'd5, 1'b1);
        chk("R10 lsb ignored valid", {15'd0, data_valid}, 16'd1);
        edges(1);
        chk("R10 lsb ignored valid next", {15'd0, data_valid}, 16'd1);
        chk("R10 lsb ignored data", dq_out, 16'hBEEF);
    endtask

    // R4, R8, R9: byte mode steering and burst steps over bytes.
    task automatic t_byte();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 18'd4, 1'b0);
        edges(5);
        chk("R8 mode change reloads full", {15'd0, data_valid}, 16'd0);
        edges(1);
        chk("R4 low byte", dq_out, 16'h0034);
        chk("R4 byte lanes", dq_oe, 16'h00FF);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 18'd4, 1'b1);
        edges(2);
        chk("R9 byte-select burst pending", {15'd0, data_valid}, 16'd0);
        edges(1);
        chk("R9 byte-select burst valid", {15'd0, data_valid}, 16'd1);
        chk("R4 high byte on low lane", dq_out, 16'h0012);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 18'd5, 1'b0);
        edges(3);
        chk("R9 word step in byte mode", {15'd0, data_valid}, 16'd1);
        chk("R4 low byte of next word", dq_out, 16'h00EF);
    endtask

    // R2: output disable.
    task automatic t_disable();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 18'd5, 1'b0);
        edges(1);
        chk("R2 disable lanes", dq_oe, 16'h0000);
        chk("R2 disable valid", {15'd0, data_valid}, 16'd0);
    endtask

    // R7, R11, R1: identifier readout, hold, standby over identifier.
    task automatic t_ident();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 18'd0, 1'b0);
        edges(6);
        chk("R7 maker code", dq_out, 16'h0007);
        chk("R8 valid after ident entry", {15'd0, data_valid}, 16'd1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFF1, 1'b1);
        chk("R7 device code, other bits ignored", dq_out, 16'h00A1);
        edges(6);
        edges(10);
        chk("R11 valid holds while stable", {15'd0, data_valid}, 16'd1);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFF1, 1'b1);
        chk("R1 standby over identifier", dq_oe, 16'h0000);
        chk("R1 standby valid low", {15'd0, data_valid}, 16'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_erased();
        t_program();
        t_word_full();
        t_word_burst();
        t_byte();
        t_disable();
        t_ident();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule